// File: doc/BRIEF.md
# Banked Edge-Event Interrupt Controller

This block collects edge events from the monitored status lines of a power-management device and presents them to a host as one interrupt line. The events sit in four 8-bit banks. Each bank has a sticky pending register, a write-one acknowledge register, and a mask that software reads directly. Software changes the mask only through a write-one-to-set register and a write-one-to-clear register, so it never needs a read-modify-write sequence. The host reaches all of these registers through a plain 8-bit address / 8-bit data port. Reads are combinational and writes take effect on the clock edge.

Seven two-edge sources (`pair_in`) each drive two independent pending bits, one for the falling edge and one for the rising edge. Sixteen single-event fault flags (`flag_in`) each raise one bit on their rising edge. The interrupt output is a registered level. It is high while any pending bit whose mask bit is 0 is set. All inputs must be synchronous to `clk`. This port has no data stream, so it has no valid/ready back-pressure: a write is accepted in the cycle `reg_wr` is high, and read data is valid in the same cycle as `reg_addr`.

Top module: `bic_top`

## Requirements
- R1: After reset, every pending register reads 0x00, mask banks 0–2 read 0xFF, mask bank 3 reads 0xCF, and `irq` is 0.
- R2: For two-edge source k, a falling edge sets the lower bit of its pair and a rising edge sets the upper bit. Sources 0–3 use bank 0, bits 2k (fall) and 2k+1 (rise). Sources 4, 5 and 6 use bank 3, bit pairs 0/1, 2/3 and 6/7.
- R3: A rising edge on `flag_in[i]` sets bank 1 bit i for i<8 and bank 2 bit i-8 for i≥8. A falling edge on a flag sets nothing.
- R4: Writing the set-mask register of bank b (address 0x2C+b) sets each mask bit written as 1. Bits written as 0 keep their value.
- R5: Writing the clear-mask register of bank b (address 0x30+b) clears each mask bit written as 1. Bits written as 0 keep their value.
- R6: The mask register of bank b (address 0x28+b) is read-only, and a write to it leaves the mask unchanged.
- R7: Pending bits (address 0x20+b) are sticky. Writing 1 to a bit of the acknowledge register (address 0x24+b) clears that bit, and writing 0 has no effect. An edge in the same cycle as the acknowledge of its bit leaves the bit set.
- R8: `irq` is, one cycle later, the OR over all banks of (pending AND NOT mask).
- R9: Bank 3 bits 4 and 5 are never raised and always read 0 in both the pending and the mask registers.
- R10: Reads of the acknowledge, set-mask and clear-mask registers and of any address outside 0x20–0x33 return 0x00. Writes outside that range change no state.
- R11: An input that is already high when reset ends raises no event in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pair_in | input | 7 | Two-edge monitored status lines |
| flag_in | input | 16 | Single-event fault flags (rising edge) |
| irq | output | 1 | Active-high interrupt level |

## Verification
The bench drives an edge into a bit in the same cycle as that bit's acknowledge. A controller that lets the acknowledge win would lose the event. It checks that zero bits in set-mask, clear-mask and acknowledge writes change nothing, and that direct writes to the mask and writes to unmapped addresses are ignored. A design that decoded these writes as full-register stores would corrupt state. It also holds a source high through reset, raises events with masking on, and then unmasks them, which catches false events after reset and an `irq` that ignores the mask or its one-cycle latency.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int unsigned BANKS  = 4;
  localparam int unsigned BANK_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SEL_W  = $clog2(BANKS);
  localparam int unsigned REG_W  = ADDR_W - SEL_W;

  // Register regions, each BANKS addresses wide
  localparam logic [ADDR_W-1:0] A_PEND = 8'h20;
  localparam logic [ADDR_W-1:0] A_ACK  = 8'h24;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] A_SETM = 8'h2C;
  localparam logic [ADDR_W-1:0] A_CLRM = 8'h30;

  // Bits that exist per bank
  function automatic logic [BANK_W-1:0] bank_valid(input int unsigned b);
    return (b == 3) ? 8'hCF : {BANK_W{1'b1}};
  endfunction

  // Bank-3 lower bit position of two-edge source k (k = 4..6)
  function automatic int unsigned hi_pair_pos(input int unsigned k);
    return (k == 6) ? 6 : 2 * (k - 4);
  endfunction
endpackage

// File: rtl/bic_edge.sv
module bic_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= sig;
      primed_q <= 1'b1;
    end
  end

  assign rise = primed_q ? (sig & ~prev_q) : '0;
  assign fall = primed_q ? (~sig & prev_q) : '0;

  // R11: no event before history is valid
  p_no_early_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed_q) |-> $past(rise == '0 && fall == '0));
endmodule

// File: rtl/bic_bank.sv
module bic_bank #(
  parameter int unsigned        W     = 8,
  parameter logic [W-1:0]       VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         ack_we,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask
);
  logic [W-1:0] pend_q, mask_q, ack_bits;

  assign ack_bits = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= VALID;
    end else begin
      pend_q <= ((pend_q & ~ack_bits) | evt) & VALID;
      if (set_we)      mask_q <= (mask_q | wdata) & VALID;
      else if (clr_we) mask_q <= mask_q & ~wdata;
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;

  p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask & $past(wdata & VALID)) == $past(wdata & VALID)));
  p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
  p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask & $past(wdata)) == '0));
  p_clr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend & ~$past(ack_bits)) == '0));
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~pend) == '0));
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend | mask) & ~VALID) == '0);
endmodule

// File: rtl/bic_top.sv
module bic_top
  import bic_pkg::*;
#(
  parameter int unsigned N_PAIR = 7,
  parameter int unsigned N_FLAG = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [6:0]  pair_in,
  input  logic [15:0] flag_in,
  output logic        irq
);
  logic [N_PAIR-1:0] p_rise, p_fall;
  logic [N_FLAG-1:0] f_rise, f_fall_unused;
  logic [BANK_W-1:0] evt  [BANKS];
  logic [BANK_W-1:0] pend [BANKS];
  logic [BANK_W-1:0] mask [BANKS];
  logic [BANKS-1:0]  bank_hit;
  logic [REG_W-1:0]  region;
  logic [SEL_W-1:0]  sel;
  logic              any_live, irq_q;

  assign region = reg_addr[ADDR_W-1:SEL_W];
  assign sel    = reg_addr[SEL_W-1:0];

  bic_edge #(.W(N_PAIR)) u_pair_edge (
    .clk(clk), .rst_n(rst_n), .sig(pair_in), .rise(p_rise), .fall(p_fall));
  bic_edge #(.W(N_FLAG)) u_flag_edge (
    .clk(clk), .rst_n(rst_n), .sig(flag_in), .rise(f_rise), .fall(f_fall_unused));

  // Event routing
  always_comb begin
    for (int b = 0; b < BANKS; b++) evt[b] = '0;
    for (int k = 0; k < 4; k++) begin
      evt[0][2*k]   = p_fall[k];
      evt[0][2*k+1] = p_rise[k];
    end
    for (int k = 4; k < N_PAIR; k++) begin
      evt[3][hi_pair_pos(k)]   = p_fall[k];
      evt[3][hi_pair_pos(k)+1] = p_rise[k];
    end
    evt[1] = f_rise[BANK_W-1:0];
    evt[2] = f_rise[2*BANK_W-1:BANK_W];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel_me;
    assign sel_me = reg_wr && (sel == SEL_W'(b));
    bic_bank #(.W(BANK_W), .VALID(bank_valid(b))) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt[b]),
      .ack_we (sel_me && region == A_ACK[ADDR_W-1:SEL_W]),
      .set_we (sel_me && region == A_SETM[ADDR_W-1:SEL_W]),
      .clr_we (sel_me && region == A_CLRM[ADDR_W-1:SEL_W]),
      .wdata  (reg_wdata),
      .pend   (pend[b]),
      .mask   (mask[b])
    );
    assign bank_hit[b] = |(pend[b] & ~mask[b]);
  end

  assign any_live = |bank_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_live;
  end
  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (region == A_PEND[ADDR_W-1:SEL_W]) reg_rdata = pend[sel];
    else if (region == A_MASK[ADDR_W-1:SEL_W]) reg_rdata = mask[sel];
  end

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(any_live)));
  p_mask_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && region == A_MASK[ADDR_W-1:SEL_W]) |=> (mask[$past(sel)] == $past(mask[sel])));
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (region < A_PEND[ADDR_W-1:SEL_W] || region > A_CLRM[ADDR_W-1:SEL_W]) |-> (reg_rdata == '0));
endmodule

// File: tb/bic_top_tb_top.sv
module bic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [6:0]  pair_in = '0;
  logic [15:0] flag_in = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    bit       is_irq;
    logic [7:0] addr;
    logic [7:0] exp;
    string    tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  bic_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pair_in(pair_in),
    .flag_in(flag_in), .irq(irq));

  // Monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {7'd0, irq} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%02h actual=%02h expected=%02h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2;
    reg_addr = a;
    sb.push_back('{1'b0, a, e, tag});
    @(negedge clk); #1;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(posedge clk); #2;
    sb.push_back('{1'b1, 8'h00, {7'd0, e}, tag});
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic drive(input logic [6:0] p, input logic [15:0] f);
    @(posedge clk); #2;
    pair_in = p; flag_in = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    pair_in[0] = 1'b1; // R11: high through reset
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 / R11
    for (int b = 0; b < 4; b++) exp_rd(8'h20 + 8'(b), 8'h00, "R1 R11 pending after reset");
    for (int b = 0; b < 3; b++) exp_rd(8'h28 + 8'(b), 8'hFF, "R1 mask after reset");
    exp_rd(8'h2B, 8'hCF, "R1 R9 bank3 mask after reset");
    exp_irq(1'b0, "R1 irq after reset");

    // R5 clear-mask, zero bits keep
    wr(8'h30, 8'h00);
    exp_rd(8'h28, 8'hFF, "R5 zero clear keeps mask");
    for (int b = 0; b < 4; b++) wr(8'h30 + 8'(b), 8'hFF);
    exp_rd(8'h28, 8'h00, "R5 mask bank0 cleared");
    exp_rd(8'h2B, 8'h00, "R5 R9 mask bank3 cleared");

    // R2 pair 0 fall then rise
    drive(7'b0000000, 16'h0000);
    exp_rd(8'h20, 8'h01, "R2 pair0 fall bit0");
    exp_irq(1'b1, "R8 irq on unmasked pending");
    drive(7'b0000001, 16'h0000);
    exp_rd(8'h20, 8'h03, "R2 pair0 rise bit1");
    drive(7'b0001001, 16'h0000); // pair3 rise
    exp_rd(8'h20, 8'h83, "R2 pair3 rise bit7");

    // R7 acknowledge
    wr(8'h24, 8'h00);
    exp_rd(8'h20, 8'h83, "R7 zero ack no effect");
    wr(8'h24, 8'h01);
    exp_rd(8'h20, 8'h82, "R7 ack clears bit0");
    wr(8'h24, 8'h82);
    exp_rd(8'h20, 8'h00, "R7 ack clears rest");
    exp_irq(1'b0, "R8 irq drops after ack");

    // R2 bank3 pairs, R9
    drive(7'b1111001, 16'h0000);
    exp_rd(8'h23, 8'h8A, "R2 R9 bank3 rises");
    drive(7'b0001001, 16'h0000);
    exp_rd(8'h23, 8'hCF, "R2 R9 bank3 falls");
    wr(8'h23 + 8'h01, 8'hFF); // ack bank3 (0x24 is bank0) - ack bank0 no-op
    wr(8'h27, 8'hFF);
    exp_rd(8'h23, 8'h00, "R7 bank3 ack all");

    // R3 flags
    drive(7'b0001001, 16'h1008);
    exp_rd(8'h21, 8'h08, "R3 flag3 to bank1");
    exp_rd(8'h22, 8'h10, "R3 flag12 to bank2");
    drive(7'b0001001, 16'h0000);
    exp_rd(8'h21, 8'h08, "R3 flag fall sets nothing bank1");
    exp_rd(8'h22, 8'h10, "R3 flag fall sets nothing bank2");
    wr(8'h25, 8'hFF);
    wr(8'h26, 8'hFF);
    exp_irq(1'b0, "R8 irq low, all acked");

    // R4 set-mask and masking
    wr(8'h2D, 8'h01);
    exp_rd(8'h29, 8'h01, "R4 set-mask bit0");
    wr(8'h2D, 8'h00);
    exp_rd(8'h29, 8'h01, "R4 zero set keeps");
    drive(7'b0001001, 16'h0001);
    exp_rd(8'h21, 8'h01, "R3 masked flag still pends");
    exp_irq(1'b0, "R8 masked pending no irq");
    // R6 direct mask write ignored
    wr(8'h29, 8'h00);
    exp_rd(8'h29, 8'h01, "R6 mask write ignored");
    exp_irq(1'b0, "R6 irq stays masked");
    wr(8'h31, 8'h01);
    exp_irq(1'b1, "R8 unmask raises irq");
    wr(8'h25, 8'h01);

    // R7 edge wins over ack in same cycle
    drive(7'b0001001, 16'h0002);
    exp_rd(8'h21, 8'h02, "R7 flag1 pend");
    drive(7'b0001001, 16'h0000);
    @(posedge clk); #2;
    flag_in = 16'h0002; reg_addr = 8'h25; reg_wdata = 8'h02; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
    exp_rd(8'h21, 8'h02, "R7 edge beats ack");

    // R10 unmapped / write-only reads
    wr(8'h00, 8'hFF);
    wr(8'hFF, 8'hFF);
    exp_rd(8'h00, 8'h00, "R10 unmapped read 0x00");
    exp_rd(8'hFF, 8'h00, "R10 unmapped read 0xFF");
    exp_rd(8'h24, 8'h00, "R10 ack reads zero");
    exp_rd(8'h2C, 8'h00, "R10 set-mask reads zero");
    exp_rd(8'h30, 8'h00, "R10 clear-mask reads zero");
    exp_rd(8'h29, 8'h00, "R10 mask unchanged by unmapped write");
    exp_rd(8'h21, 8'h02, "R10 pending unchanged by unmapped write");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule